// File: doc/BRIEF.md
# Register File with Constant, Flag, Stack and Program-Counter Registers

This block holds sixteen 32-bit registers for a small processor core. Two read ports are combinational. One write port is shared by the general datapath. Two side channels serve the stack pointer and the program counter. Two entries never change: one always reads zero and the other always reads one. Another entry carries the condition flags and the selected ALU operation, and its top bit always reads as set.

The write port has three forms. A full write replaces the destination. A byte-lane write changes only the low eight bits and leaves the rest alone, so byte loads and byte immediates do not zero-extend or sign-extend. A scaled-offset write stores the value of the register selected on read port A plus four times a signed 4-bit count.

The stack pointer steps by four on a push or pop strobe. The program counter can be loaded through its own port. Both registers are also mirrored on dedicated outputs.

Top module: `spreg_file`

## Requirements
- R1: Register 0 always reads 0x0000_0000 and register 1 always reads 0x0000_0001 on every read port. A write to either address changes no register.
- R2: A full write (`wrEn`=1, `wrByte`=0, `wrOffs`=0) to address 2..15 stores `wrData` into that register.
- R3: With no general write to register 14, `spPush` alone lowers the stack pointer by 4 and `spPop` alone raises it by 4, wrapping modulo 2^32. Both strobes together leave it unchanged.
- R4: Register 13 always reads with bit 31 set. Its bits 30..0 read back as written.
- R5: A write with `wrByte`=1 replaces bits [7:0] of the destination and keeps bits [31:8].
- R6: A write with `wrOffs`=1 uses as its value the current read-port-A value plus 4 times `offsN`. `offsN` is read as two's complement, so the range is -8..7. It combines with `wrByte` like any other write value.
- R7: A general write to register 14 overrides a push or pop in the same cycle. A general write to register 15 overrides a `pcWrEn` load in the same cycle.
- R8: `pcWrEn`=1 loads `pcWrData` into register 15. `spOut` and `pcOut` always equal registers 14 and 15.
- R9: While `rstN` is low, every register reads 0 except register 1, which reads 1, and register 13, which reads 0x8000_0000.
- R10: The read ports are combinational from stored state. A write becomes visible only after the rising clock edge that takes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| rdAddrA | input | 4 | Read port A address; also the offset-write source |
| rdAddrB | input | 4 | Read port B address |
| rdDataA | output | 32 | Read port A data |
| rdDataB | output | 32 | Read port B data |
| wrEn | input | 1 | General write enable |
| wrAddr | input | 4 | General write destination |
| wrData | input | 32 | General write data |
| wrByte | input | 1 | Byte-lane write, bits [7:0] only |
| wrOffs | input | 1 | Write value is port A plus 4 times offsN |
| offsN | input | 4 | Signed offset count |
| spPush | input | 1 | Stack pointer minus 4 |
| spPop | input | 1 | Stack pointer plus 4 |
| pcWrEn | input | 1 | Program counter load strobe |
| pcWrData | input | 32 | Program counter load value |
| spOut | output | 32 | Current stack pointer |
| pcOut | output | 32 | Current program counter |

## Verification
The write port is driven three ways: with full words, with byte-lane data over registers that already hold values in their upper bits, and with scaled offsets at -8, 0 and 7. Together these separate a correct byte merge from zero-extension and a correct sign extension from an unsigned one. The stack strobes are applied alone, together, and in collision with general writes to register 14. This distinguishes stepping from priority. Random traffic that mixes all of these against a reference model also targets the constant and flag addresses, which checks that their fixed values hold under arbitrary writes.

// File: rtl/spreg_pkg.sv
package spreg_pkg;
  localparam int DATA_W   = 32;
  localparam int NUM_REGS = 16;
  localparam int ADDR_W   = $clog2(NUM_REGS);
  localparam int NUM_RD   = 2;
  localparam int OFFS_W   = 4;
  localparam int STEP_SH  = 2;                 // offset and stack step are in units of 4
  localparam int LANE_W   = 8;
  localparam int IDX_ZERO = 0;
  localparam int IDX_ONE  = 1;
  localparam int IDX_FLAG = 13;
  localparam int IDX_SP   = 14;
  localparam int IDX_PC   = 15;
  localparam logic [DATA_W-1:0] SP_STEP = DATA_W'(1 << STEP_SH);

  typedef struct packed {
    logic [NUM_REGS-1:0] wrSel;   // one-hot destination, constants masked out
    logic                byteLane;
    logic                useOffs;
    logic                spDec;
    logic                spInc;
    logic                pcLoad;
  } rfStrobe_t;
endpackage

// File: rtl/spreg_ctrl.sv
module spreg_ctrl
  import spreg_pkg::*;
(
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic              wrByte,
  input  logic              wrOffs,
  input  logic              spPush,
  input  logic              spPop,
  input  logic              pcWrEn,
  output rfStrobe_t         strobe
);
  logic [NUM_REGS-1:0] decSel;

  always_comb begin
    decSel = '0;
    if (wrEn) decSel[wrAddr] = 1'b1;
    decSel[IDX_ZERO] = 1'b0;
    decSel[IDX_ONE]  = 1'b0;
  end

  always_comb begin
    strobe.wrSel    = decSel;
    strobe.byteLane = wrByte;
    strobe.useOffs  = wrOffs;
    // general write to the stack pointer wins over stepping
    strobe.spDec    = spPush & ~spPop & ~decSel[IDX_SP];
    strobe.spInc    = spPop & ~spPush & ~decSel[IDX_SP];
    strobe.pcLoad   = pcWrEn & ~decSel[IDX_PC];
  end
endmodule

// File: rtl/spreg_dp.sv
module spreg_dp
  import spreg_pkg::*;
(
  input  logic                           clk,
  input  logic                           rstN,
  input  rfStrobe_t                      strobe,
  input  logic [NUM_RD-1:0][ADDR_W-1:0]  rdAddr,
  output logic [NUM_RD-1:0][DATA_W-1:0]  rdData,
  input  logic [DATA_W-1:0]              wrData,
  input  logic [OFFS_W-1:0]              offsN,
  input  logic [DATA_W-1:0]              pcWrData,
  output logic [DATA_W-1:0]              spOut,
  output logic [DATA_W-1:0]              pcOut
);
  localparam int EXT_W = DATA_W - OFFS_W - STEP_SH;

  logic [NUM_REGS-1:0][DATA_W-1:0] regQ;
  logic [NUM_REGS-1:0][DATA_W-1:0] regD;
  logic [DATA_W-1:0] offsVal;
  logic [DATA_W-1:0] wrVal;

  // read ports: one mux per port
  for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
    always_comb begin
      unique case (rdAddr[p])
        ADDR_W'(IDX_ZERO): rdData[p] = '0;
        ADDR_W'(IDX_ONE):  rdData[p] = DATA_W'(1);
        ADDR_W'(IDX_FLAG): rdData[p] = regQ[IDX_FLAG] | {1'b1, {(DATA_W-1){1'b0}}};
        default:           rdData[p] = regQ[rdAddr[p]];
      endcase
    end
  end

  assign offsVal = rdData[0] + {{EXT_W{offsN[OFFS_W-1]}}, offsN, {STEP_SH{1'b0}}};
  assign wrVal   = strobe.useOffs ? offsVal : wrData;

  always_comb begin
    for (int i = 0; i < NUM_REGS; i++) begin
      regD[i] = regQ[i];
      if (strobe.wrSel[i]) begin
        if (strobe.byteLane) regD[i] = {regQ[i][DATA_W-1:LANE_W], wrVal[LANE_W-1:0]};
        else                 regD[i] = wrVal;
      end
    end
    if (strobe.spDec) regD[IDX_SP] = regQ[IDX_SP] - SP_STEP;
    if (strobe.spInc) regD[IDX_SP] = regQ[IDX_SP] + SP_STEP;
    if (strobe.pcLoad) regD[IDX_PC] = pcWrData;
    regD[IDX_ZERO] = '0;
    regD[IDX_ONE]  = DATA_W'(1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_REGS; i++) regQ[i] <= (i == IDX_ONE) ? DATA_W'(1) : '0;
    end else begin
      regQ <= regD;
    end
  end

  assign spOut = regQ[IDX_SP];
  assign pcOut = regQ[IDX_PC];
endmodule

// File: rtl/spreg_file.sv
module spreg_file
  import spreg_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [3:0]        rdAddrA,
  input  logic [3:0]        rdAddrB,
  output logic [31:0]       rdDataA,
  output logic [31:0]       rdDataB,
  input  logic              wrEn,
  input  logic [3:0]        wrAddr,
  input  logic [31:0]       wrData,
  input  logic              wrByte,
  input  logic              wrOffs,
  input  logic [3:0]        offsN,
  input  logic              spPush,
  input  logic              spPop,
  input  logic              pcWrEn,
  input  logic [31:0]       pcWrData,
  output logic [31:0]       spOut,
  output logic [31:0]       pcOut
);
  rfStrobe_t strobe;
  logic [NUM_RD-1:0][ADDR_W-1:0] rdAddr;
  logic [NUM_RD-1:0][DATA_W-1:0] rdData;

  assign rdAddr[0] = rdAddrA;
  assign rdAddr[1] = rdAddrB;
  assign rdDataA   = rdData[0];
  assign rdDataB   = rdData[1];

  spreg_ctrl u_ctrl (
    .wrEn(wrEn), .wrAddr(wrAddr), .wrByte(wrByte), .wrOffs(wrOffs),
    .spPush(spPush), .spPop(spPop), .pcWrEn(pcWrEn), .strobe(strobe)
  );

  spreg_dp u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .rdAddr(rdAddr), .rdData(rdData),
    .wrData(wrData), .offsN(offsN), .pcWrData(pcWrData), .spOut(spOut), .pcOut(pcOut)
  );
endmodule

// File: rtl/spreg_file_chk.sv
module spreg_file_chk (
  input logic        clk,
  input logic        rstN,
  input logic [3:0]  rdAddrA,
  input logic [31:0] rdDataA,
  input logic [3:0]  rdAddrB,
  input logic [31:0] rdDataB,
  input logic        wrEn,
  input logic [3:0]  wrAddr,
  input logic [31:0] wrData,
  input logic        wrByte,
  input logic        wrOffs,
  input logic        spPush,
  input logic        spPop,
  input logic        pcWrEn,
  input logic [31:0] pcWrData,
  input logic [31:0] spOut,
  input logic [31:0] pcOut
);
  // R1: constant entries
  p_zero_const_r1: assert property (@(posedge clk) disable iff (!rstN)
    (rdAddrA == 4'd0) |-> (rdDataA == 32'd0));
  p_one_const_r1: assert property (@(posedge clk) disable iff (!rstN)
    (rdAddrB == 4'd1) |-> (rdDataB == 32'd1));
  // R4: flag top bit
  p_flag_msb_r4: assert property (@(posedge clk) disable iff (!rstN)
    (rdAddrA == 4'd13) |-> rdDataA[31]);
  // R3: stepping alone
  p_push_step_r3: assert property (@(posedge clk) disable iff (!rstN)
    (spPush && !spPop && !(wrEn && wrAddr == 4'd14)) |=> (spOut == $past(spOut) - 32'd4));
  p_pop_step_r3: assert property (@(posedge clk) disable iff (!rstN)
    (spPop && !spPush && !(wrEn && wrAddr == 4'd14)) |=> (spOut == $past(spOut) + 32'd4));
  // R7: general write to SP overrides stepping
  p_sp_prio_r7: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr == 4'd14 && !wrByte && !wrOffs) |=> (spOut == $past(wrData)));
  // R5: byte write to PC keeps upper bits
  p_byte_keep_r5: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrByte && wrAddr == 4'd15) |=> (pcOut[31:8] == $past(pcOut[31:8])));
  // R8: PC load without a colliding general write
  p_pc_load_r8: assert property (@(posedge clk) disable iff (!rstN)
    (pcWrEn && !(wrEn && wrAddr == 4'd15)) |=> (pcOut == $past(pcWrData)));
endmodule

bind spreg_file spreg_file_chk u_chk (
  .clk(clk), .rstN(rstN), .rdAddrA(rdAddrA), .rdDataA(rdDataA), .rdAddrB(rdAddrB),
  .rdDataB(rdDataB), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData), .wrByte(wrByte),
  .wrOffs(wrOffs), .spPush(spPush), .spPop(spPop), .pcWrEn(pcWrEn),
  .pcWrData(pcWrData), .spOut(spOut), .pcOut(pcOut)
);

// File: tb/spreg_file_tb.sv
`timescale 1ns/1ps
module spreg_file_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [3:0]  rdAddrA = '0, rdAddrB = '0, wrAddr = '0, offsN = '0;
  logic [31:0] rdDataA, rdDataB, spOut, pcOut;
  logic [31:0] wrData = '0, pcWrData = '0;
  logic        wrEn = 0, wrByte = 0, wrOffs = 0, spPush = 0, spPop = 0, pcWrEn = 0;

  int checks = 0;
  int fails  = 0;
  logic [31:0] m [16];

  always #2.5 clk = ~clk;

  spreg_file dut_i (.*);

  function automatic logic [31:0] mrd(input logic [3:0] a);
    if (a == 0) return 32'd0;
    if (a == 1) return 32'd1;
    if (a == 13) return m[13] | 32'h8000_0000;
    return m[a];
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic modelStep();
    logic [31:0] v;
    logic [31:0] n [16];
    for (int i = 0; i < 16; i++) n[i] = m[i];
    v = wrOffs ? mrd(rdAddrA) + {{26{offsN[3]}}, offsN, 2'b00} : wrData;
    if (wrEn && wrAddr > 1) n[wrAddr] = wrByte ? {m[wrAddr][31:8], v[7:0]} : v;
    if (!(wrEn && wrAddr == 14)) begin
      if (spPush && !spPop) n[14] = m[14] - 32'd4;
      if (spPop && !spPush) n[14] = m[14] + 32'd4;
    end
    if (pcWrEn && !(wrEn && wrAddr == 15)) n[15] = pcWrData;
    for (int i = 0; i < 16; i++) m[i] = n[i];
  endtask

  // drive after a falling edge, check pre-edge reads, clock, check post-edge
  task automatic step(input string tag, input logic we, input logic [3:0] wa,
                      input logic [31:0] wd, input logic wb, input logic wo,
                      input logic [3:0] on, input logic pu, input logic po,
                      input logic pe, input logic [31:0] pd,
                      input logic [3:0] ra, input logic [3:0] rb);
    wrEn = we; wrAddr = wa; wrData = wd; wrByte = wb; wrOffs = wo; offsN = on;
    spPush = pu; spPop = po; pcWrEn = pe; pcWrData = pd; rdAddrA = ra; rdAddrB = rb;
    #1;
    chk({tag, " R10 pre-edge B"}, rdDataB, mrd(rb));
    @(posedge clk);
    modelStep();
    @(negedge clk);
    wrEn = 0; spPush = 0; spPop = 0; pcWrEn = 0;
    #0.5;
    chk({tag, " A"}, rdDataA, mrd(ra));
    chk({tag, " B"}, rdDataB, mrd(rb));
    chk({tag, " R8 sp"}, spOut, m[14]);
    chk({tag, " R8 pc"}, pcOut, m[15]);
  endtask

  initial begin
    #100000;
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int unsigned seed = 32'd7;
    void'($urandom(seed));
    for (int i = 0; i < 16; i++) m[i] = 32'd0;
    #7;
    // R9 reset state
    for (int a = 0; a < 16; a++) begin
      rdAddrA = 4'(a); #0.5;
      chk("R9 reset read", rdDataA, (a == 1) ? 32'd1 : (a == 13) ? 32'h8000_0000 : 32'd0);
    end
    @(negedge clk); rstN = 1'b1;
    // R1 writes to constants ignored
    step("R1 w0", 1, 0, 32'hDEAD_BEEF, 0, 0, 0, 0, 0, 0, 0, 0, 1);
    step("R1 w1", 1, 1, 32'hFFFF_FFFF, 0, 0, 0, 0, 0, 0, 0, 1, 0);
    // R2 full writes
    step("R2 w5", 1, 5, 32'h1234_5678, 0, 0, 0, 0, 0, 0, 0, 5, 5);
    // R4 flag register
    step("R4 w13 zero", 1, 13, 32'h0000_0000, 0, 0, 0, 0, 0, 0, 0, 13, 13);
    step("R4 w13 ones", 1, 13, 32'h7FFF_FFFF, 0, 0, 0, 0, 0, 0, 0, 13, 13);
    // R3 stack stepping from zero wraps
    step("R3 push", 0, 0, 0, 0, 0, 0, 1, 0, 0, 0, 14, 14);
    chk("R3 push wrap", spOut, 32'hFFFF_FFFC);
    step("R3 pop", 0, 0, 0, 0, 0, 0, 0, 1, 0, 0, 14, 14);
    chk("R3 pop back", spOut, 32'd0);
    step("R3 both", 0, 0, 0, 0, 0, 0, 1, 1, 0, 0, 14, 14);
    chk("R3 both unchanged", spOut, 32'd0);
    // R7 priority
    step("R7 sp", 1, 14, 32'h0000_1000, 0, 0, 0, 1, 0, 0, 0, 14, 14);
    chk("R7 sp wins", spOut, 32'h0000_1000);
    step("R7 pc", 1, 15, 32'h0000_0200, 0, 0, 0, 0, 0, 1, 32'h0000_0999, 15, 15);
    chk("R7 pc wins", pcOut, 32'h0000_0200);
    // R8 PC load
    step("R8 load", 0, 0, 0, 0, 0, 0, 0, 0, 1, 32'hCAFE_0004, 15, 15);
    chk("R8 pc loaded", pcOut, 32'hCAFE_0004);
    // R5 byte lane keeps upper bits
    step("R5 byte", 1, 5, 32'hFFFF_FFAB, 1, 0, 0, 0, 0, 0, 0, 5, 5);
    chk("R5 byte merge", rdDataA, 32'h1234_56AB);
    // R6 offsets -8, 0, 7
    step("R6 neg", 1, 6, 0, 0, 1, 4'h8, 0, 0, 0, 0, 14, 6);
    chk("R6 n=-8", rdDataB, 32'h0000_0FE0);
    step("R6 pos", 1, 7, 0, 0, 1, 4'h7, 0, 0, 0, 0, 14, 7);
    chk("R6 n=7", rdDataB, 32'h0000_101C);
    step("R6 zero src", 1, 8, 0, 0, 1, 4'h0, 0, 0, 0, 0, 1, 8);
    chk("R6 n=0 from one", rdDataB, 32'd1);
    step("R6 byte", 1, 5, 0, 1, 1, 4'h1, 0, 0, 0, 0, 14, 5);
    chk("R6 byte offs", rdDataB, 32'h1234_5604);
    // random mix
    for (int k = 0; k < 600; k++) begin
      logic [3:0] wa = 4'($urandom_range(15, 0));
      step("R2 rand", 1'($urandom), wa, $urandom, 1'($urandom_range(3, 0) == 0),
           1'($urandom_range(3, 0) == 0), 4'($urandom), 1'($urandom), 1'($urandom),
           1'($urandom_range(3, 0) == 0), $urandom,
           4'($urandom), ($urandom_range(1, 0) == 1) ? wa : 4'($urandom));
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule